// File: doc/BRIEF.md
# Descriptor-Driven Command Launcher

This block is the register front end of a guest-to-host channel device. Software can still program the channel, transfer size and buffer address one register at a time. It can also place a six-word parameter block in memory, give the block its 64-bit location through two 32-bit registers, and write a single launch register. The block then does the rest on its own:

- it reads the parameter block over a simple request/acknowledge memory master port;
- it loads its working registers from that block;
- it starts the command on a downstream start/done command port, if the command is one it is allowed to run;
- it writes the whole block back to memory, with the command status placed in the result word.

A one-cycle completion pulse ends every sequence that reaches memory. The busy output is high while a sequence runs. The actual buffer movement belongs to whatever sits behind the command port.

Top module: `pblk_front`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `cmd_start` are 0, and every readable register reads 0.
- R2: The descriptor address low half (bits 31:0) is at offset 0x18 and the high half (bits 63:32) at offset 0x1c. Both halves can be read back. Writing one half leaves the other half unchanged.
- R3: While idle, a write of any value to offset 0x20 with a nonzero descriptor address starts a sequence, and `busy` is high on the next cycle. The block then reads six words, one at a time, at base + 4*i for i = 0..5. The words are, in this order: channel, size, buffer address, command code, result, flags. Each request is held with stable address until `mem_ack`.
- R4: A write to 0x20 while the descriptor address is zero does nothing: no memory request, no `busy`, no `done`.
- R5: The fetched channel, size and buffer address words overwrite the registers at offsets 0x08, 0x0c and 0x10. This also happens when the command is not executed. While idle, software can write these registers directly.
- R6: Command code 4 (read buffer) and command code 5 (write buffer) are executed. `cmd_start` pulses for one cycle, with `cmd_code`, `cmd_chan`, `cmd_size` and `cmd_addr` carrying the fetched values. The block then waits for `cmd_done` and captures `cmd_status`.
- R7: Any other command code gives no `cmd_start` and no memory write. The sequence ends with a `done` pulse, and the memory block is left untouched.
- R8: After execution, six writes go to base + 4*i in ascending order. Each word equals the fetched word, except word 4, which carries the captured status. A one-cycle `done` pulse follows, and `busy` then drops.
- R9: While `busy` is high, every register write is ignored, including further launch writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |
| cmd_start | output | 1 | One-cycle command start |
| cmd_code | output | DW | Command code |
| cmd_chan | output | DW | Channel register |
| cmd_size | output | DW | Size register |
| cmd_addr | output | DW | Buffer address register |
| cmd_done | input | 1 | Command finished |
| cmd_status | input | DW | Status, valid with `cmd_done` |

## Verification
The bench builds the block with its defaults: 32-bit data, 64-bit descriptor address and command codes 4 and 5. The full 64-bit address path is therefore exercised with nonzero high halves, including a base whose low half is zero. Its memory model acknowledges every other cycle, so each request is held across a wait cycle. The command stub answers three cycles after start, with a status derived from the channel and the code. This makes the executed path, the filtered codes 0, 2 and 6, the zero-address case and writes issued mid-sequence all reachable and checkable at the ports.

// File: rtl/pblk_front.sv
module pblk_front #(
  parameter int DW     = 32,
  parameter int AW     = 64,
  parameter int RAW    = 8,
  parameter int CMD_RD = 4,
  parameter int CMD_WR = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           busy,
  output logic           done,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic           cmd_start,
  output logic [DW-1:0]  cmd_code,
  output logic [DW-1:0]  cmd_chan,
  output logic [DW-1:0]  cmd_size,
  output logic [DW-1:0]  cmd_addr,
  input  logic           cmd_done,
  input  logic [DW-1:0]  cmd_status
);
  localparam int NW   = 6;
  localparam int IW   = $clog2(NW);
  localparam int HALF = AW / 2;
  localparam int W_CH = 0, W_SZ = 1, W_AD = 2, W_CMD = 3, W_RES = 4;
  localparam logic [RAW-1:0] OFS_CH = RAW'(8'h08);
  localparam logic [RAW-1:0] OFS_SZ = RAW'(8'h0c);
  localparam logic [RAW-1:0] OFS_AD = RAW'(8'h10);
  localparam logic [RAW-1:0] OFS_LO = RAW'(8'h18);
  localparam logic [RAW-1:0] OFS_HI = RAW'(8'h1c);
  localparam logic [RAW-1:0] OFS_GO = RAW'(8'h20);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_START, S_WAIT, S_WB, S_DONE} st_t;

  st_t            st;
  logic [IW-1:0]  idx;
  logic [AW-1:0]  pa;
  logic [DW-1:0]  blk [NW];
  logic [DW-1:0]  chan_q, size_q, baddr_q, stat_q;
  logic           go_wr;
  logic           last;

  assign go_wr     = reg_we && (reg_addr == OFS_GO);
  assign last      = (idx == IW'(NW-1));
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign mem_req   = (st == S_FETCH) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = pa + (AW'(idx) << 2);
  assign mem_wdata = (idx == IW'(W_RES)) ? stat_q : blk[idx];
  assign cmd_start = (st == S_START);
  assign cmd_code  = blk[W_CMD];
  assign cmd_chan  = chan_q;
  assign cmd_size  = size_q;
  assign cmd_addr  = baddr_q;

  always_comb begin
    case (reg_addr)
      OFS_CH:  reg_rdata = chan_q;
      OFS_SZ:  reg_rdata = size_q;
      OFS_AD:  reg_rdata = baddr_q;
      OFS_LO:  reg_rdata = pa[HALF-1:0];
      OFS_HI:  reg_rdata = pa[AW-1:HALF];
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      pa      <= '0;
      chan_q  <= '0;
      size_q  <= '0;
      baddr_q <= '0;
      stat_q  <= '0;
      for (int i = 0; i < NW; i++) blk[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (reg_we) begin
            case (reg_addr)
              OFS_CH:  chan_q  <= reg_wdata;
              OFS_SZ:  size_q  <= reg_wdata;
              OFS_AD:  baddr_q <= reg_wdata;
              OFS_LO:  pa[HALF-1:0]  <= reg_wdata;
              OFS_HI:  pa[AW-1:HALF] <= reg_wdata;
              default: ;
            endcase
          end
          if (go_wr && (pa != '0)) begin
            idx <= '0;
            st  <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            blk[idx] <= mem_rdata;
            if (idx == IW'(W_CH)) chan_q  <= mem_rdata;
            if (idx == IW'(W_SZ)) size_q  <= mem_rdata;
            if (idx == IW'(W_AD)) baddr_q <= mem_rdata;
            if (last) st <= S_CHECK;
            else      idx <= idx + 1'b1;
          end
        end
        S_CHECK: begin
          if (blk[W_CMD] == DW'(CMD_RD) || blk[W_CMD] == DW'(CMD_WR)) st <= S_START;
          else st <= S_DONE;
        end
        S_START: st <= S_WAIT;
        S_WAIT: begin
          if (cmd_done) begin
            stat_q <= cmd_status;
            idx    <= '0;
            st     <= S_WB;
          end
        end
        S_WB: begin
          if (mem_ack) begin
            if (last) st <= S_DONE;
            else      idx <= idx + 1'b1;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pblk_front_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic [AW-1:0] pa,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          cmd_start
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !cmd_start && !done));

  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && pa != '0) |=> (busy && mem_req && !mem_we && mem_addr == $past(pa)));

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r4_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && pa == '0) |=> (!busy && !mem_req));

  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (!cmd_start && busy && !mem_req));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

bind pblk_front pblk_front_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go_wr), .pa(pa), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .cmd_start(cmd_start)
);

// File: tb/sim_pblk_front.sv
module sim_pblk_front;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        busy, done, mem_req, mem_we, mem_ack, cmd_start, cmd_done;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, cmd_code, cmd_chan, cmd_size, cmd_addr, cmd_status;

  always #10 clk = ~clk;

  pblk_front u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cmd_start(cmd_start), .cmd_code(cmd_code), .cmd_chan(cmd_chan), .cmd_size(cmd_size),
    .cmd_addr(cmd_addr), .cmd_done(cmd_done), .cmd_status(cmd_status)
  );

  int checks = 0, failures = 0;
  logic [31:0] mem [64];
  int rds = 0, wrs = 0, addr_bad = 0, xfer_i = 0, starts = 0, dones = 0;
  logic [63:0] exp_base = 0;
  logic [31:0] seen_code, seen_chan, seen_size, seen_addr;
  int dly = 0;

  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 0;
    else begin
      if (mem_req && mem_ack) begin
        if (mem_we) begin mem[mem_addr[7:2]] <= mem_wdata; wrs++; end
        else rds++;
        if (mem_addr != exp_base + 64'(4 * xfer_i)) addr_bad++;
        xfer_i = (xfer_i == 5) ? 0 : xfer_i + 1;
      end
      mem_ack <= mem_req && !mem_ack;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin cmd_done <= 0; cmd_status <= 0; dly = 0; end
    else begin
      cmd_done <= 0;
      if (cmd_start) begin
        starts++; seen_code <= cmd_code; seen_chan <= cmd_chan;
        seen_size <= cmd_size; seen_addr <= cmd_addr; dly = 3;
      end else if (dly != 0) begin
        dly--;
        if (dly == 0) begin
          cmd_done   <= 1;
          cmd_status <= cmd_chan ^ 32'h5A5A_0000 ^ (cmd_code << 8);
        end
      end
      if (done) dones++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done(input int limit);
    int d0 = dones;
    for (int i = 0; i < limit && dones == d0; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] stat_of(input logic [31:0] ch, input logic [31:0] cd);
    return ch ^ 32'h5A5A_0000 ^ (cd << 8);
  endfunction

  task automatic load_blk(input int wi, input logic [31:0] ch, sz, ad, cd, input int tagv);
    mem[wi] = ch; mem[wi+1] = sz; mem[wi+2] = ad; mem[wi+3] = cd;
    mem[wi+4] = 32'hDEAD_0000 | tagv; mem[wi+5] = 32'hF1A6_0000 | tagv;
  endtask

  // channel, size, buffer address, command
  localparam logic [127:0] VEC [6] = '{
    {32'h3, 32'h100,  32'hA000, 32'd4},
    {32'h7, 32'h20,   32'hB004, 32'd5},
    {32'h9, 32'h44,   32'hC008, 32'd2},
    {32'h1, 32'h8,    32'hD00C, 32'd0},
    {32'hF, 32'h1000, 32'hE010, 32'd5},
    {32'h2, 32'h4,    32'hF014, 32'd6}
  };

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !done && !mem_req && !cmd_start, "R1 outputs idle", {busy, done, mem_req, cmd_start}, 0);
    rd(8'h18, v); chk(v == 0, "R1 low reg", v, 0);
    rd(8'h1c, v); chk(v == 0, "R1 high reg", v, 0);
    rd(8'h08, v); chk(v == 0, "R1 chan reg", v, 0);

    // R2 halves
    wr(8'h18, 32'h1234_5678); wr(8'h1c, 32'h9ABC_DEF0);
    rd(8'h18, v); chk(v == 32'h1234_5678, "R2 low readback", v, 32'h1234_5678);
    rd(8'h1c, v); chk(v == 32'h9ABC_DEF0, "R2 high readback", v, 32'h9ABC_DEF0);
    wr(8'h18, 32'h11);
    rd(8'h1c, v); chk(v == 32'h9ABC_DEF0, "R2 high kept", v, 32'h9ABC_DEF0);
    wr(8'h1c, 32'h22);
    rd(8'h18, v); chk(v == 32'h11, "R2 low kept", v, 32'h11);

    // R5 direct write while idle
    wr(8'h08, 32'h77);
    rd(8'h08, v); chk(v == 32'h77, "R5 direct chan write", v, 32'h77);

    // R4 zero address
    wr(8'h18, 0); wr(8'h1c, 0);
    begin
      int r0 = rds, d0 = dones;
      wr(8'h20, 32'hFFFF_FFFF);
      chk(!busy, "R4 no busy", busy, 0);
      repeat (10) @(negedge clk);
      chk(rds == r0 && dones == d0 && !busy, "R4 no memory access", rds - r0, 0);
    end

    // vector table: R3 R5 R6 R7 R8
    for (int i = 0; i < 6; i++) begin
      logic [31:0] ch, sz, ad, cd;
      int wi, r0, w0, s0, b0;
      bit ex;
      {ch, sz, ad, cd} = VEC[i];
      wi = 16 + 8 * i;
      ex = (cd == 4) || (cd == 5);
      load_blk(wi, ch, sz, ad, cd, i);
      exp_base = {32'(i + 1), 32'(wi * 4)};
      xfer_i = 0;
      r0 = rds; w0 = wrs; s0 = starts; b0 = addr_bad;
      wr(8'h18, exp_base[31:0]); wr(8'h1c, exp_base[63:32]);
      wr(8'h20, 32'h0);
      chk(busy, "R3 busy after launch", busy, 1);
      wait_done(300);
      @(negedge clk);
      chk(!busy, "R8 busy cleared", busy, 0);
      chk(rds - r0 == 6, "R3 six reads", rds - r0, 6);
      chk(addr_bad == b0, "R3 ascending addresses", addr_bad - b0, 0);
      rd(8'h08, v); chk(v == ch, "R5 channel loaded", v, ch);
      rd(8'h0c, v); chk(v == sz, "R5 size loaded", v, sz);
      rd(8'h10, v); chk(v == ad, "R5 address loaded", v, ad);
      if (ex) begin
        chk(starts - s0 == 1, "R6 one start", starts - s0, 1);
        chk(seen_code == cd && seen_chan == ch && seen_size == sz && seen_addr == ad,
            "R6 command fields", seen_code, cd);
        chk(wrs - w0 == 6, "R8 six writes", wrs - w0, 6);
        chk(mem[wi+4] == stat_of(ch, cd), "R8 result word", mem[wi+4], stat_of(ch, cd));
        chk(mem[wi+2] == ad && mem[wi+5] == (32'hF1A6_0000 | i), "R8 other words kept", mem[wi+5], 32'hF1A6_0000 | i);
      end else begin
        chk(starts == s0, "R7 no start", starts - s0, 0);
        chk(wrs == w0, "R7 no write-back", wrs - w0, 0);
        chk(mem[wi+4] == (32'hDEAD_0000 | i), "R7 result untouched", mem[wi+4], 32'hDEAD_0000 | i);
      end
    end

    // R3 low half zero, high half nonzero is a valid base
    load_blk(0, 32'h5, 32'h10, 32'h900, 32'd4, 9);
    exp_base = 64'h1_0000_0000; xfer_i = 0;
    wr(8'h18, 0); wr(8'h1c, 1);
    wr(8'h20, 1);
    chk(busy, "R3 high-only base launches", busy, 1);
    wait_done(300);
    chk(mem[4] == stat_of(32'h5, 32'd4), "R8 high-only result", mem[4], stat_of(32'h5, 32'd4));

    // R9 writes ignored while busy
    begin
      int r0, d0;
      load_blk(32, 32'h6, 32'h30, 32'h700, 32'd5, 10);
      exp_base = {32'h2, 32'h80}; xfer_i = 0;
      wr(8'h18, 32'h80); wr(8'h1c, 32'h2);
      r0 = rds; d0 = dones;
      wr(8'h20, 0);
      wr(8'h18, 32'h44);
      wr(8'h20, 0);
      wr(8'h08, 32'h99);
      wait_done(300);
      repeat (30) @(negedge clk);
      chk(rds - r0 == 6 && dones - d0 == 1, "R9 relaunch ignored", rds - r0, 6);
      rd(8'h18, v); chk(v == 32'h80, "R9 low write ignored", v, 32'h80);
      rd(8'h08, v); chk(v == 32'h6, "R9 chan write ignored", v, 32'h6);
      chk(mem[36] == stat_of(32'h6, 32'd5), "R9 result of single run", mem[36], stat_of(32'h6, 32'd5));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule